// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block drives the control pins of an asynchronous single-data-rate NAND flash for one transfer at a time. A transfer can be a command byte, an address byte, a byte written to the flash or a byte read from it. The block lowers chip enable and drives the latch-enable pins that select what kind of transfer it is. It then pulses write-enable or read-enable low for a programmed number of controller clocks. Every phase length comes from a packed 32-bit timing word, which resets to a conservative default and can be reloaded from the `cfg_word` input.

Requests arrive on a valid/ready port. `req_ready` is high only while no transfer is running. A request held on the port while `req_ready` is low stays pending and is taken once the transfer in flight ends. A byte read from the flash is offered on a valid/ready result port. That byte stays valid and stable until it is accepted, and no new request is taken until then.

Three status pins report progress. One shows that a command transfer is pending and one shows that an address transfer is pending. The third is a busy flag that follows the flash ready/busy pin. After each command, the busy flag is forced on for a programmable window so that the flash has time to pull its pin low.

Top module: `nand_strobe_seq`

## Requirements
- R1: Out of reset, chip enable, write-enable and read-enable are high, both latch enables are low, `req_ready` is high and all status pins are low. The timing word defaults to post-hold 3, pre-setup 3, enable-to-read 7, write-to-read 7, strobe-high 15, write-low 15 and read-low 15.
- R2: Timing word fields by bit position: [3:0] read-low, [7:4] write-low, [11:8] strobe-high, [15:12] write-to-read, [21:16] enable-to-read, [27:22] pre-setup, [31:28] post-hold. A strobe stays low for its field value plus one clocks, and strobe-high lasts its field value plus one clocks.
- R3: A write-low or read-low field below 3 is treated as 3, so the strobe is low for 4 clocks.
- R4: Chip enable falls, then pre-setup clocks pass, then the strobe falls. After the strobe rises, chip enable stays low for strobe-high plus one plus post-hold clocks. A strobe is never low while chip enable is high.
- R5: A read waits enable-to-read clocks after pre-setup before read-enable falls. It captures the data bus on the last clock that read-enable is low.
- R6: A read that immediately follows a command, address or write transfer inserts twice the write-to-read value in clocks before the enable-to-read wait. A read that follows a read inserts nothing.
- R7: Request kind encoding is 0 command, 1 address, 2 write, 3 read. The command latch enable is high only for kind 0 and the address latch enable only for kind 1. Write-enable pulses for kinds 0 to 2 while the data bus is driven with the request byte. Read-enable pulses for kind 3 with the bus released. Write-enable and read-enable are never low together.
- R8: `req_ready` stays low from acceptance until chip enable rises again. No request is taken during that time.
- R9: A read result is held on `rd_valid`/`rd_data` without change until `rd_ready` is high. It is removed on the clock that accepts it.
- R10: The command-pending status rises on the clock after a kind 0 request is accepted, and the address-pending status does the same for kind 1. Each clears on the clock that ends its transfer.
- R11: The busy status equals the inverted flash ready/busy pin after a two-flop synchronizer. It is also forced high for `rb_wait`×16 clocks starting at the end of every command transfer, and for no other transfer kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load `cfg_word` into the timing register |
| cfg_word | input | 32 | New timing word |
| rb_wait | input | 4 | Busy mask length after a command, in units of 16 clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this clock when valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_byte | input | 8 | Command, address or write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Byte captured from the flash |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Flash ready/busy, low when busy |
| stat_cmd_pend | output | 1 | Command transfer pending |
| stat_addr_pend | output | 1 | Address transfer pending |
| stat_busy | output | 1 | Flash busy or busy mask running |

## Verification
The bench measures each strobe width and the setup and hold spans from the pins. It covers zero-length setup and hold phases, and strobe-low fields below the minimum: a design without the clamp would give a 1- to 3-clock pulse. Reads run both after a write-enable transfer and after another read. A turnaround applied in the wrong place would shift read-enable by twice the write-to-read field. The bench moves the data bus right after read-enable rises, so a capture made one clock late returns the wrong byte. It holds off the read consumer to catch a result that is dropped or changes before it is accepted. It counts the busy mask after a command to the exact clock and confirms that an address transfer leaves no mask.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int CNT_W         = 7;
  localparam int STROBE_LO_MIN = 3;
  localparam int TW_W          = 32;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_kind_e;

  // packed MSB first: field positions are part of the programming model
  typedef struct packed {
    logic [3:0] post_hold;
    logic [5:0] pre_setup;
    logic [5:0] ce_to_re;
    logic [3:0] we_to_re;
    logic [3:0] strobe_hi;
    logic [3:0] we_lo;
    logic [3:0] re_lo;
  } timing_t;

  localparam timing_t TIMING_RESET = '{post_hold: 4'd3, pre_setup: 6'd3, ce_to_re: 6'd7,
                                        we_to_re: 4'd7, strobe_hi: 4'd15, we_lo: 4'd15,
                                        re_lo: 4'd15};

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_TURN  = 3'd2,
    PH_C2R   = 3'd3,
    PH_LO    = 3'd4,
    PH_HI    = 3'd5,
    PH_HOLD  = 3'd6,
    PH_RDOUT = 3'd7
  } phase_e;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t setup;
    cnt_t turn;
    cnt_t c2r;
    cnt_t we_lo;
    cnt_t re_lo;
    cnt_t hi;
    cnt_t hold;
  } lens_t;

  function automatic cnt_t len_of(lens_t l, phase_e ph, logic rd);
    cnt_t r;
    case (ph)
      PH_SETUP: r = l.setup;
      PH_TURN:  r = l.turn;
      PH_C2R:   r = l.c2r;
      PH_LO:    r = rd ? l.re_lo : l.we_lo;
      PH_HI:    r = l.hi;
      PH_HOLD:  r = l.hold;
      default:  r = cnt_t'(1);
    endcase
    return r;
  endfunction

  function automatic phase_e next_ph(phase_e ph, logic rd);
    phase_e r;
    case (ph)
      PH_SETUP: r = rd ? PH_TURN : PH_LO;
      PH_TURN:  r = PH_C2R;
      PH_C2R:   r = PH_LO;
      PH_LO:    r = PH_HI;
      PH_HI:    r = PH_HOLD;
      PH_HOLD:  r = rd ? PH_RDOUT : PH_IDLE;
      default:  r = PH_IDLE;
    endcase
    return r;
  endfunction

  // walk past phases whose programmed length is zero
  function automatic phase_e skip_empty(lens_t l, phase_e ph, logic rd);
    phase_e p;
    p = ph;
    for (int i = 0; i < 4; i++) begin
      if ((p == PH_SETUP || p == PH_TURN || p == PH_C2R || p == PH_HOLD) &&
          len_of(l, p, rd) == '0)
        p = next_ph(p, rd);
    end
    return p;
  endfunction
endpackage

// File: rtl/nst_timing_reg.sv
module nst_timing_reg
  import nst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [TW_W-1:0] cfg_word,
  output lens_t           lens
);
  timing_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= TIMING_RESET;
    else if (cfg_load) cfg_q <= timing_t'(cfg_word);
  end

  logic [3:0] lo_raw [2];
  cnt_t       lo_len [2];
  assign lo_raw[0] = cfg_q.we_lo;
  assign lo_raw[1] = cfg_q.re_lo;

  for (genvar g = 0; g < 2; g++) begin : g_lo_clamp
    assign lo_len[g] = (lo_raw[g] < 4'(STROBE_LO_MIN)) ? cnt_t'(STROBE_LO_MIN + 1)
                                                       : cnt_t'(lo_raw[g]) + cnt_t'(1);
  end

  assign lens = '{setup: cnt_t'(cfg_q.pre_setup),
                  turn:  cnt_t'({cfg_q.we_to_re, 1'b0}),
                  c2r:   cnt_t'(cfg_q.ce_to_re),
                  we_lo: lo_len[0],
                  re_lo: lo_len[1],
                  hi:    cnt_t'(cfg_q.strobe_hi) + cnt_t'(1),
                  hold:  cnt_t'(cfg_q.post_hold)};
endmodule

// File: rtl/nst_phase_seq.sv
module nst_phase_seq
  import nst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lens_t      lens,
  input  logic       req_valid,
  output logic       req_ready,
  input  op_kind_e   req_kind,
  input  logic [7:0] req_byte,
  input  logic [7:0] dq_in,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output phase_e     phase,
  output op_kind_e   kind,
  output logic [7:0] byte_out,
  output logic       cycle_done
);
  phase_e     phase_q;
  cnt_t       cnt_q;
  op_kind_e   kind_q;
  logic [7:0] byte_q;
  logic [7:0] rd_q;
  logic       last_we_q;

  lens_t eff;
  always_comb begin
    eff = lens;
    if (!last_we_q) eff.turn = '0;
  end

  logic req_rd, cur_rd, active;
  assign req_rd = (req_kind == OP_READ);
  assign cur_rd = (kind_q == OP_READ);
  assign active = (phase_q != PH_IDLE) && (phase_q != PH_RDOUT);

  phase_e first_ph, after_ph;
  always_comb begin
    first_ph = skip_empty(eff, PH_SETUP, req_rd);
    after_ph = skip_empty(eff, next_ph(phase_q, cur_rd), cur_rd);
  end

  assign cycle_done = active && (cnt_q == '0) &&
                      (after_ph == PH_IDLE || after_ph == PH_RDOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      kind_q    <= OP_CMD;
      byte_q    <= '0;
      rd_q      <= '0;
      last_we_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            phase_q <= first_ph;
            cnt_q   <= len_of(eff, first_ph, req_rd) - cnt_t'(1);
            kind_q  <= req_kind;
            byte_q  <= req_byte;
          end
        end
        PH_RDOUT: begin
          if (rd_ready) phase_q <= PH_IDLE;
        end
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - cnt_t'(1);
          end else begin
            if (phase_q == PH_LO && cur_rd) rd_q <= dq_in;
            phase_q <= after_ph;
            cnt_q   <= len_of(eff, after_ph, cur_rd) - cnt_t'(1);
            if (cycle_done) last_we_q <= !cur_rd;
          end
        end
      endcase
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rd_valid  = (phase_q == PH_RDOUT);
  assign rd_data   = rd_q;
  assign phase     = phase_q;
  assign kind      = kind_q;
  assign byte_out  = byte_q;
endmodule

// File: rtl/nst_status.sv
module nst_status
  import nst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MASK_SHIFT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  op_kind_e   acc_kind,
  input  logic       cycle_done,
  input  op_kind_e   done_kind,
  input  logic       rb_n,
  input  logic [3:0] rb_wait,
  output logic       stat_cmd_pend,
  output logic       stat_addr_pend,
  output logic       stat_busy
);
  localparam int TMR_W = 4 + MASK_SHIFT;

  logic [SYNC_STAGES-1:0] rb_sync;
  always_ff @(posedge clk) begin
    if (!rst_n) rb_sync <= '1;
    else        rb_sync <= {rb_sync[SYNC_STAGES-2:0], rb_n};
  end

  logic cmd_q, addr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
    end else if (accept) begin
      cmd_q  <= (acc_kind == OP_CMD);
      addr_q <= (acc_kind == OP_ADDR);
    end else if (cycle_done) begin
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
    end
  end

  logic [TMR_W-1:0] tmr_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                tmr_q <= '0;
    else if (cycle_done && done_kind == OP_CMD) tmr_q <= {rb_wait, {MASK_SHIFT{1'b0}}};
    else if (tmr_q != '0)                      tmr_q <= tmr_q - TMR_W'(1);
  end

  assign stat_cmd_pend  = cmd_q;
  assign stat_addr_pend = addr_q;
  assign stat_busy      = (tmr_q != '0) || !rb_sync[SYNC_STAGES-1];
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [31:0] cfg_word,
  input  logic [3:0]  rb_wait,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_byte,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb_n,
  output logic        stat_cmd_pend,
  output logic        stat_addr_pend,
  output logic        stat_busy
);
  lens_t      lens;
  phase_e     phase;
  op_kind_e   kind;
  logic [7:0] byte_q;
  logic       cycle_done;
  op_kind_e   req_kind_e;

  assign req_kind_e = op_kind_e'(req_kind);

  nst_timing_reg u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_word (cfg_word),
    .lens     (lens)
  );

  nst_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .lens       (lens),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind_e),
    .req_byte   (req_byte),
    .dq_in      (nand_dq_in),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .phase      (phase),
    .kind       (kind),
    .byte_out   (byte_q),
    .cycle_done (cycle_done)
  );

  nst_status #(.SYNC_STAGES(2), .MASK_SHIFT(4)) u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (req_valid && req_ready),
    .acc_kind       (req_kind_e),
    .cycle_done     (cycle_done),
    .done_kind      (kind),
    .rb_n           (nand_rb_n),
    .rb_wait        (rb_wait),
    .stat_cmd_pend  (stat_cmd_pend),
    .stat_addr_pend (stat_addr_pend),
    .stat_busy      (stat_busy)
  );

  logic active, strobe;
  assign active = (phase != PH_IDLE) && (phase != PH_RDOUT);
  assign strobe = (phase == PH_LO);

  assign nand_ce_n   = !active;
  assign nand_cle    = active && (kind == OP_CMD);
  assign nand_ale    = active && (kind == OP_ADDR);
  assign nand_we_n   = !(strobe && kind != OP_READ);
  assign nand_re_n   = !(strobe && kind == OP_READ);
  assign nand_dq_oe  = active && (kind != OP_READ);
  assign nand_dq_out = byte_q;
endmodule

// File: rtl/nst_checker.sv
module nst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_kind,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       stat_cmd_pend,
  input logic       stat_addr_pend
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n)); // R7
  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n) (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R4
  AST_STALL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !nand_ce_n |-> !req_ready); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_CMD_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_kind == 2'd0) |=> stat_cmd_pend); // R10
  AST_PEND_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!stat_cmd_pend && !stat_addr_pend)); // R10
  AST_WE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(nand_we_n) |-> (!$past(nand_we_n, 2) && !$past(nand_we_n, 3) && !$past(nand_we_n, 4))); // R3
  AST_RE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(nand_re_n) |-> (!$past(nand_re_n, 2) && !$past(nand_re_n, 3) && !$past(nand_re_n, 4))); // R3
endmodule

bind nand_strobe_seq nst_checker u_nst_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_kind       (req_kind),
  .rd_valid       (rd_valid),
  .rd_ready       (rd_ready),
  .rd_data        (rd_data),
  .nand_ce_n      (nand_ce_n),
  .nand_cle       (nand_cle),
  .nand_ale       (nand_ale),
  .nand_we_n      (nand_we_n),
  .nand_re_n      (nand_re_n),
  .stat_cmd_pend  (stat_cmd_pend),
  .stat_addr_pend (stat_addr_pend)
);

// File: tb/tb_nand_strobe_seq.sv
`timescale 1ns/1ps
module tb_nand_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [3:0]  rb_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_byte = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb_n = 1'b1;
  logic        stat_cmd_pend, stat_addr_pend, stat_busy;

  always #2.5 clk = ~clk;

  nand_strobe_seq dut (.*);

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int po, int pr, int c2r, int w2r, int wh, int wst, int rlt);
    return {po[3:0], pr[5:0], c2r[5:0], w2r[3:0], wh[3:0], wst[3:0], rlt[3:0]};
  endfunction

  typedef struct packed {
    logic [31:0] tw;
    logic [1:0]  k;
    logic [7:0]  b;
    logic [7:0]  pre;
    logic [7:0]  lo;
    logic [7:0]  post;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{mk(2, 3, 5, 2, 1, 4, 5),        2'd0, 8'h70, 8'd3,  8'd5,  8'd4},
    '{mk(1, 0, 5, 2, 0, 2, 5),        2'd1, 8'h12, 8'd0,  8'd4,  8'd2},
    '{mk(0, 4, 5, 2, 3, 7, 5),        2'd2, 8'h5A, 8'd4,  8'd8,  8'd4},
    '{mk(1, 2, 3, 2, 1, 4, 5),        2'd3, 8'hC3, 8'd9,  8'd6,  8'd3},
    '{mk(0, 1, 6, 5, 0, 4, 0),        2'd3, 8'h3C, 8'd7,  8'd4,  8'd1},
    '{mk(15, 63, 63, 15, 15, 15, 15), 2'd0, 8'hFF, 8'd63, 8'd16, 8'd31}
  };

  // one transfer, measured from the pins at falling edges
  task automatic run_op(input logic [1:0] k, input logic [7:0] b, input int hold,
                        output int pre, output int lo, output int post,
                        output bit role_ok, output bit stall_ok, output bit stat_ok,
                        output bit rd_ok);
    bit seen;
    int guard;
    pre = 0; lo = 0; post = 0; seen = 1'b0; guard = 0;
    role_ok = 1'b1; stall_ok = 1'b1; stat_ok = 1'b1; rd_ok = 1'b1;
    nand_dq_in = b;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (!nand_ce_n && guard < 400) begin
      guard++;
      if (req_ready) stall_ok = 1'b0;
      if (stat_cmd_pend != (k == 2'd0) || stat_addr_pend != (k == 2'd1)) stat_ok = 1'b0;
      if (!nand_we_n || !nand_re_n) begin
        lo++; seen = 1'b1;
        if (nand_cle != (k == 2'd0) || nand_ale != (k == 2'd1)) role_ok = 1'b0;
        if (k == 2'd3) begin
          if (nand_re_n || !nand_we_n || nand_dq_oe) role_ok = 1'b0;
        end else begin
          if (nand_we_n || !nand_re_n || !nand_dq_oe || nand_dq_out != b) role_ok = 1'b0;
        end
      end else if (!seen) begin
        pre++;
      end else begin
        post++;
        if (k == 2'd3) nand_dq_in = ~b;
      end
      @(negedge clk);
    end
    if (stat_cmd_pend || stat_addr_pend) stat_ok = 1'b0;
    if (k == 2'd3) begin
      if (!rd_valid || rd_data != b || req_ready) rd_ok = 1'b0;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if (!rd_valid || rd_data != b || req_ready) rd_ok = 1'b0;
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      if (rd_valid || !req_ready) rd_ok = 1'b0;
    end else begin
      if (rd_valid || !req_ready) stall_ok = 1'b0;
    end
  endtask

  task automatic load_timing(input logic [31:0] w);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int pre, lo, post, n;
    bit role_ok, stall_ok, stat_ok, rd_ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pin state after reset
    check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe &&
          req_ready && !rd_valid && !stat_cmd_pend && !stat_addr_pend && !stat_busy,
          "R1", 0, 1);

    // R1: default timing word measured on a command transfer
    run_op(2'd0, 8'h90, 0, pre, lo, post, role_ok, stall_ok, stat_ok, rd_ok);
    check(pre == 3, "R1", pre, 3);
    check(lo == 16, "R1", lo, 16);
    check(post == 19, "R1", post, 19);

    // vector table: timing fields, clamps, turnaround, roles, status
    for (int i = 0; i < NV; i++) begin
      load_timing(VECS[i].tw);
      run_op(VECS[i].k, VECS[i].b, 0, pre, lo, post, role_ok, stall_ok, stat_ok, rd_ok);
      check(pre == int'(VECS[i].pre), (VECS[i].k == 2'd3) ? "R6" : "R4", pre, int'(VECS[i].pre));
      check(lo == int'(VECS[i].lo), (i == 1 || i == 4) ? "R3" : "R2", lo, int'(VECS[i].lo));
      check(post == int'(VECS[i].post), "R4", post, int'(VECS[i].post));
      check(role_ok, "R7", 0, 1);
      check(stall_ok, "R8", 0, 1);
      check(stat_ok, "R10", 0, 1);
      if (VECS[i].k == 2'd3) check(rd_ok, "R5", int'(rd_data), int'(VECS[i].b));
    end

    // R9: read result held while consumer stalls; follows a command so R6 turnaround applies
    load_timing(mk(0, 1, 2, 1, 0, 3, 3));
    run_op(2'd3, 8'hA7, 4, pre, lo, post, role_ok, stall_ok, stat_ok, rd_ok);
    check(rd_ok, "R9", 0, 1);
    check(pre == 5, "R6", pre, 5);
    check(lo == 4, "R2", lo, 4);

    // R8: request held during a transfer is taken afterwards, not lost
    load_timing(mk(1, 2, 2, 1, 1, 4, 4));
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_byte = 8'h44;
    @(negedge clk);
    req_kind = 2'd2; req_byte = 8'h66;
    n = 0;
    while (!nand_ce_n && n < 100) begin n++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (nand_we_n && n < 100) begin n++; @(negedge clk); end
    check(!nand_ale && !nand_cle && nand_dq_out == 8'h66, "R8", int'(nand_dq_out), 8'h66);
    while (!nand_ce_n) @(negedge clk);

    // R11: busy mask after a command, exact length
    rb_wait = 4'd2;
    run_op(2'd0, 8'hE0, 0, pre, lo, post, role_ok, stall_ok, stat_ok, rd_ok);
    n = 0;
    while (stat_busy && n < 200) begin n++; @(negedge clk); end
    check(n == 32, "R11", n, 32);

    // R11: an address transfer starts no mask
    run_op(2'd1, 8'h01, 0, pre, lo, post, role_ok, stall_ok, stat_ok, rd_ok);
    check(!stat_busy, "R11", int'(stat_busy), 0);

    // R11: busy follows the flash pin through the synchronizer
    nand_rb_n = 1'b0;
    @(negedge clk);
    check(!stat_busy, "R11", int'(stat_busy), 0);
    @(negedge clk);
    check(stat_busy, "R11", int'(stat_busy), 1);
    nand_rb_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!stat_busy, "R11", int'(stat_busy), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule